// File: doc/BRIEF.md
# Masked I2C Slave Address Matcher

This block decides whether an I2C slave acknowledges the address that a master sends after a START or a repeated START. A byte-level front end handles the pins and the framing. It hands over each received byte with a flag that marks the first byte after a START. The matcher compares that byte, and for a 10-bit address the byte after it, against two programmable slave addresses. One address is 7-bit and the other is 10-bit, and each has its own enable. For each address byte it returns one acknowledge decision. It also keeps an addressed-as-slave flag and a flag that says which address length matched.

The 10-bit compare uses a programmable mask, so one slave can answer a whole family of addresses. When a masked 10-bit match completes, the full received address is written back into the 10-bit address register, where software can read it. Configuration is written only while the interface enable is low.

Bytes enter on a valid/ready stream, and decisions leave on a second valid/ready stream. A decision is raised one clock after its byte is accepted. It stays valid, with its value unchanged, until `dec_ready` is seen high. `in_ready` equals `!dec_valid || dec_ready`. A byte is taken only in a cycle where both `in_valid` and `in_ready` are high, so the block never holds more than one decision in flight.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, register 0 reads 16'h3FFF: bit 15 (10-bit enable) is 0, bit 14 (length flag) is 0, and bits 9:0 (mask) are all 1. Register 1 (10-bit address, bits 9:0) reads 0. Register 2 (bit 7 = 7-bit enable, bits 6:0 = 7-bit address) reads 0. `addressed` and `dec_valid` are 0.
- R2: Bits 13:10 of register 0 always read as 1. All other unused register bits read as 0.
- R3: A write to register 0, 1 or 2 while `enable` is 1 is ignored. The register reads back unchanged.
- R4: A first byte whose bits 7:1 equal the 7-bit address, with the 7-bit enable set, is acknowledged. It sets `addressed` to 1 and `len_flag` to 0. This compare is tried before the 10-bit one.
- R5: A first byte of 11110, A9, A8, W (bit 0 = 0), with the 10-bit enable set, is acknowledged when A9:A8 match under the mask. `addressed` goes to 0 and the block waits for the next byte. If the second byte completes a masked match of all 10 bits, that byte is acknowledged, `addressed` goes to 1 and `len_flag` goes to 1.
- R6: A mask bit of 0 makes that address bit a don't-care. A difference in an address bit whose mask bit is 1 gives a not-acknowledge on that byte and sets `addressed` to 0.
- R7: When a 10-bit match completes, register 1 takes the 10 address bits that were actually received.
- R8: With the 10-bit enable at 0, no 10-bit header byte is acknowledged.
- R9: `addressed` is cleared by `stop_evt`, and by a first byte that matches nothing. When `enable` is 0, `addressed`, `len_flag` and any pending 10-bit compare are all cleared.
- R10: Each address byte gives exactly one decision. A byte that is neither a first byte nor the second byte of a 10-bit address is consumed and gives no decision. While `dec_ready` is 0, a decision stays valid and keeps its value, and `in_ready` is 0.
- R11: A first byte 11110, A9, A8, R (bit 0 = 1) is acknowledged when the slave is currently addressed as 10-bit and A9:A8 equal bits 9:8 of register 1. Both flags then keep their values. Any other read header is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Interface enable; configuration writes are only accepted while it is 0 |
| in_valid | input | 1 | Received byte is valid |
| in_ready | output | 1 | Matcher can accept a byte |
| in_byte | input | 8 | Received byte, MSB first on the bus |
| in_first | input | 1 | Byte is the first one after a START or repeated START |
| stop_evt | input | 1 | One-cycle STOP condition pulse |
| dec_valid | output | 1 | Acknowledge decision is valid |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| addressed | output | 1 | Addressed-as-slave flag |
| len_flag | output | 1 | 0 = matched the 7-bit address, 1 = matched the 10-bit address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 control/mask, 1 10-bit address, 2 7-bit address) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |

## Verification
The assertions assume a well-behaved front end. It raises `stop_evt` for a single cycle, never in the same cycle as an accepted byte, and it holds `dec_ready` high often enough for decisions to drain. The bench keeps to these rules. It drives every byte, stop pulse and register strobe from the falling edge, one event at a time. It lowers `enable` around every reconfiguration, except in the deliberate locked-write cases. The random received addresses are drawn as the programmed address with a few random bits flipped. This mixes masked hits, unmasked misses and non-header bytes.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int BYTE_W = 8;
  localparam int TEN_W  = 10;
  localparam int SEV_W  = 7;
  localparam int REG_W  = 16;
  localparam int RA_W   = 2;
  localparam int HI_W   = TEN_W - BYTE_W;
  localparam int HDR_W  = BYTE_W - HI_W - 1;
  localparam logic [HDR_W-1:0] HDR_TEN = 5'b11110;
  localparam logic [RA_W-1:0] RA_CTRL = 2'd0;
  localparam logic [RA_W-1:0] RA_TEN  = 2'd1;
  localparam logic [RA_W-1:0] RA_SEV  = 2'd2;
  localparam int BIT_TEN_EN = REG_W - 1;
  localparam int BIT_LEN    = REG_W - 2;

  typedef struct packed {
    logic             ten_en;
    logic [TEN_W-1:0] mask;
    logic [TEN_W-1:0] addr10;
    logic             sev_en;
    logic [SEV_W-1:0] addr7;
  } am_cfg_t;
endpackage

// File: rtl/am_regs.sv
module am_regs
  import i2c_am_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             reg_wr,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             wb_en,
  input  logic [TEN_W-1:0] wb_addr,
  input  logic             len_flag,
  output logic [REG_W-1:0] reg_rdata,
  output am_cfg_t          cfg
);
  logic sw_wr;
  assign sw_wr = reg_wr && !enable;

  wire unused_wbits = ^{reg_wdata[BIT_LEN:TEN_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.ten_en <= 1'b0;
      cfg.mask   <= '1;
      cfg.addr10 <= '0;
      cfg.sev_en <= 1'b0;
      cfg.addr7  <= '0;
    end else if (sw_wr) begin
      case (reg_addr)
        RA_CTRL: begin
          cfg.ten_en <= reg_wdata[BIT_TEN_EN];
          cfg.mask   <= reg_wdata[TEN_W-1:0];
        end
        RA_TEN: cfg.addr10 <= reg_wdata[TEN_W-1:0];
        RA_SEV: begin
          cfg.sev_en <= reg_wdata[SEV_W];
          cfg.addr7  <= reg_wdata[SEV_W-1:0];
        end
        default: ;
      endcase
    end else if (wb_en) begin
      cfg.addr10 <= wb_addr;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[BIT_TEN_EN]     = cfg.ten_en;
        reg_rdata[BIT_LEN]        = len_flag;
        reg_rdata[BIT_LEN-1:TEN_W] = '1;
        reg_rdata[TEN_W-1:0]      = cfg.mask;
      end
      RA_TEN: reg_rdata[TEN_W-1:0] = cfg.addr10;
      RA_SEV: reg_rdata[SEV_W:0]   = {cfg.sev_en, cfg.addr7};
      default: ;
    endcase
  end

  // R3: configuration is frozen while the interface runs
  assert_locked_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && reg_wr) |=> ($stable(cfg.mask) && $stable(cfg.ten_en) &&
                            $stable(cfg.sev_en) && $stable(cfg.addr7)));
  // R7: write-back happens only on a live interface
  assert_wb_only_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> enable);
endmodule

// File: rtl/am_compare.sv
module am_compare
  import i2c_am_pkg::*;
(
  input  am_cfg_t           cfg,
  input  logic [BYTE_W-1:0] rx,
  input  logic [HI_W-1:0]   held_hi,
  output logic              sev_hit,
  output logic              hdr_w_hit,
  output logic              hdr_r_hit,
  output logic              full_hit
);
  logic              is_hdr;
  logic [HI_W-1:0]   rx_hi;
  logic [TEN_W-1:0]  diff_full;
  logic [HI_W-1:0]   diff_hi;

  assign is_hdr = cfg.ten_en && (rx[BYTE_W-1 -: HDR_W] == HDR_TEN);
  assign rx_hi  = rx[HI_W:1];
  assign sev_hit = cfg.sev_en && (rx[BYTE_W-1:1] == cfg.addr7);

  assign diff_hi   = (rx_hi ^ cfg.addr10[TEN_W-1 -: HI_W]) & cfg.mask[TEN_W-1 -: HI_W];
  assign diff_full = ({held_hi, rx} ^ cfg.addr10) & cfg.mask;

  assign hdr_w_hit = is_hdr && !rx[0] && (diff_hi == '0);
  assign hdr_r_hit = is_hdr &&  rx[0] && (rx_hi == cfg.addr10[TEN_W-1 -: HI_W]);
  assign full_hit  = cfg.ten_en && (diff_full == '0);
endmodule

// File: rtl/am_seq.sv
module am_seq
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_first,
  input  logic              stop_evt,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_ack,
  output logic              addressed,
  output logic              len_flag,
  input  logic              sev_hit,
  input  logic              hdr_w_hit,
  input  logic              hdr_r_hit,
  input  logic              full_hit,
  output logic [HI_W-1:0]   held_hi,
  output logic              wb_en,
  output logic [TEN_W-1:0]  wb_addr
);
  logic pend;
  logic take;

  assign in_ready = !dec_valid || dec_ready;
  assign take     = in_valid && in_ready && enable && !stop_evt;
  assign wb_en    = take && !in_first && pend && full_hit;
  assign wb_addr  = {held_hi, in_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      held_hi   <= '0;
      addressed <= 1'b0;
      len_flag  <= 1'b0;
      dec_valid <= 1'b0;
      dec_ack   <= 1'b0;
    end else begin
      if (dec_valid && dec_ready) dec_valid <= 1'b0;
      if (!enable) begin
        pend      <= 1'b0;
        addressed <= 1'b0;
        len_flag  <= 1'b0;
      end else if (stop_evt) begin
        pend      <= 1'b0;
        addressed <= 1'b0;
      end else if (take) begin
        if (in_first) begin
          pend      <= 1'b0;
          dec_valid <= 1'b1;
          if (sev_hit) begin
            dec_ack   <= 1'b1;
            addressed <= 1'b1;
            len_flag  <= 1'b0;
          end else if (hdr_r_hit && addressed && len_flag) begin
            dec_ack   <= 1'b1;
          end else if (hdr_w_hit) begin
            dec_ack   <= 1'b1;
            pend      <= 1'b1;
            held_hi   <= in_byte[HI_W:1];
            addressed <= 1'b0;
          end else begin
            dec_ack   <= 1'b0;
            addressed <= 1'b0;
          end
        end else if (pend) begin
          pend      <= 1'b0;
          dec_valid <= 1'b1;
          dec_ack   <= full_hit;
          addressed <= full_hit;
          if (full_hit) len_flag <= 1'b1;
        end
      end
    end
  end

  // R9: disabling clears the length flag
  assert_len_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !len_flag);
  // R9: STOP drops the addressed state
  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && enable) |=> !addressed);
  // R10: a pending decision holds under back-pressure
  assert_dec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_ack)));
  // R4: becoming addressed coincides with an acknowledge
  assert_addr_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> (dec_valid && dec_ack));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_first,
  input  logic              stop_evt,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_ack,
  output logic              addressed,
  output logic              len_flag,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  am_cfg_t          cfg;
  logic             sev_hit, hdr_w_hit, hdr_r_hit, full_hit;
  logic [HI_W-1:0]  held_hi;
  logic             wb_en;
  logic [TEN_W-1:0] wb_addr;

  am_regs u_regs (
    .clk(clk), .rst_n(rst_n), .enable(enable), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .wb_en(wb_en),
    .wb_addr(wb_addr), .len_flag(len_flag), .reg_rdata(reg_rdata), .cfg(cfg)
  );

  am_compare u_cmp (
    .cfg(cfg), .rx(in_byte), .held_hi(held_hi), .sev_hit(sev_hit),
    .hdr_w_hit(hdr_w_hit), .hdr_r_hit(hdr_r_hit), .full_hit(full_hit)
  );

  am_seq u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .in_first(in_first),
    .stop_evt(stop_evt), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_ack(dec_ack), .addressed(addressed), .len_flag(len_flag),
    .sev_hit(sev_hit), .hdr_w_hit(hdr_w_hit), .hdr_r_hit(hdr_r_hit),
    .full_hit(full_hit), .held_hi(held_hi), .wb_en(wb_en), .wb_addr(wb_addr)
  );
endmodule

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_byte = '0;
  logic in_first = 1'b0;
  logic stop_evt = 1'b0;
  logic dec_valid;
  logic dec_ready = 1'b1;
  logic dec_ack;
  logic addressed;
  logic len_flag;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 0;

  // model of the programmed and observed state
  bit m_en, m_ten, m_sev, m_addr, m_len, m_pend;
  logic [9:0] m_mask = 10'h3FF, m_a10 = '0;
  logic [6:0] m_a7 = '0;
  logic [1:0] m_hi = '0;

  i2c_addr_match uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .in_first(in_first),
    .stop_evt(stop_evt), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_ack(dec_ack), .addressed(addressed), .len_flag(len_flag),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: act=hung exp=finished");
    summary();
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit masked_eq(logic [9:0] a, logic [9:0] b, logic [9:0] m);
    return ((a ^ b) & m) == 10'h0;
  endfunction

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (!m_en) begin
      case (a)
        2'd0: begin m_ten = d[15]; m_mask = d[9:0]; end
        2'd1: m_a10 = d[9:0];
        2'd2: begin m_sev = d[7]; m_a7 = d[6:0]; end
        default: ;
      endcase
    end
  endtask

  task automatic set_en(bit v);
    @(negedge clk);
    enable = v;
    @(negedge clk);
    m_en = v;
    if (!v) begin m_addr = 0; m_len = 0; m_pend = 0; end
    check("R9 flags after enable change", {addressed, len_flag}, {m_addr, m_len});
  endtask

  task automatic do_stop();
    @(negedge clk);
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
    m_addr = 0; m_pend = 0;
    check("R9 addressed after stop", addressed, 1'b0);
  endtask

  // send one byte; model computes the expected decision and flags
  task automatic send(string req, logic [7:0] b, bit first);
    bit emit = 0, ack = 0, wb = 0;
    logic [15:0] d;
    if (m_en) begin
      if (first) begin
        bit hdr = m_ten && (b[7:3] == 5'b11110);
        emit = 1; m_pend = 0;
        if (m_sev && b[7:1] == m_a7) begin
          ack = 1; m_addr = 1; m_len = 0;
        end else if (hdr && b[0] && b[2:1] == m_a10[9:8] && m_addr && m_len) begin
          ack = 1;
        end else if (hdr && !b[0] && (((b[2:1] ^ m_a10[9:8]) & m_mask[9:8]) == 2'b0)) begin
          ack = 1; m_pend = 1; m_hi = b[2:1]; m_addr = 0;
        end else begin
          ack = 0; m_addr = 0;
        end
      end else if (m_pend) begin
        emit = 1; m_pend = 0;
        ack = masked_eq({m_hi, b}, m_a10, m_mask);
        m_addr = ack;
        if (ack) begin m_len = 1; m_a10 = {m_hi, b}; wb = 1; end
      end
    end
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_first = first;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " dec_valid"}, dec_valid, emit);
    if (emit) check({req, " dec_ack"}, dec_ack, ack);
    check({req, " flags"}, {addressed, len_flag}, {m_addr, m_len});
    if (wb) begin
      rd(2'd1, d);
      check("R7 write-back", d, {6'h0, m_a10});
    end
  endtask

  logic [15:0] rv;

  initial begin
    void'($urandom(32'd20240611));
    m_en = 0; m_ten = 0; m_sev = 0; m_addr = 0; m_len = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, rv); check("R1 ctrl reset", rv, 16'h3FFF);
    rd(2'd1, rv); check("R1 ten reset", rv, 16'h0000);
    rd(2'd2, rv); check("R1 sev reset", rv, 16'h0000);
    check("R1 outputs reset", {addressed, dec_valid, len_flag}, 3'b000);

    wr(2'd2, 16'h00D2);           // 7-bit enabled, address 0x52
    wr(2'd1, 16'h02A5);
    wr(2'd0, 16'h83FF);           // 10-bit enabled, full mask
    rd(2'd0, rv); check("R2 ctrl ones", rv, 16'hBFFF);
    set_en(1);

    send("R5 header", 8'hF4, 1);
    send("R5 exact 10-bit", 8'hA5, 0);
    send("R4 7-bit match", 8'hA4, 1);
    send("R5 header again", 8'hF4, 1);
    send("R6 unmasked miss", 8'hA4, 0);
    send("R10 data byte", 8'h33, 0);

    wr(2'd0, 16'h0000);
    rd(2'd0, rv); check("R3 ctrl locked", rv, 16'hBFFF);
    wr(2'd1, 16'h0000);
    rd(2'd1, rv); check("R3 ten locked", rv, 16'h02A5);

    set_en(0);
    wr(2'd0, 16'h83F0);           // low nibble don't care
    set_en(1);
    send("R6 masked header", 8'hF4, 1);
    send("R6 masked match", 8'hAC, 0);
    send("R11 read restart", 8'hF5, 1);
    do_stop();
    send("R11 read header not addressed", 8'hF5, 1);

    set_en(0);
    wr(2'd0, 16'h03FF);
    set_en(1);
    send("R8 ten disabled", 8'hF4, 1);

    // R10 back-pressure
    @(negedge clk); dec_ready = 1'b0;
    send("R10 stalled 7-bit", 8'hA4, 1);
    repeat (2) @(negedge clk);
    check("R10 held valid", dec_valid, 1'b1);
    check("R10 held ack", dec_ack, 1'b1);
    check("R10 in_ready low", in_ready, 1'b0);
    dec_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", dec_valid, 1'b0);

    // constrained random traffic
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op == 0) begin
        set_en(0);
        wr(2'd0, {1'($urandom_range(0, 3) != 0), 5'h0, 10'($urandom | 32'h300)});
        wr(2'd1, 16'($urandom_range(0, 1023)));
        wr(2'd2, {8'h0, 1'($urandom_range(0, 1)), 7'($urandom)});
        set_en(1);
      end else if (op == 1) begin
        do_stop();
      end else if (op == 2) begin
        send("R10 random data", 8'($urandom), 0);
      end else if (op <= 4) begin
        logic [6:0] a = m_a7 ^ (7'($urandom) & 7'($urandom) & 7'($urandom));
        send("R4 random 7-bit", {a, 1'($urandom_range(0, 1))}, 1);
      end else begin
        logic [9:0] a = m_a10 ^ (10'($urandom) & 10'($urandom) & 10'($urandom));
        send("R5 random header", {5'b11110, a[9:8], 1'($urandom_range(0, 5) == 0)}, 1);
        send("R6 random low byte", a[7:0], 0);
      end
    end
    summary();
  end
endmodule